// File: doc/BRIEF.md
# Indirect PCI Transaction Launcher

This block lets a host processor issue single PCI transactions without a mapped window into PCI space. Software programs a target address and, for writes, a data word into two host-visible registers. It then writes a command register that holds the PCI command code, active-low byte enables and two trigger bits. A read-type command written together with the read trigger, or a write-type command written together with the write trigger, starts one transaction. The transaction goes to a PCI master engine over a simple request / accept / done handshake.

Completion time depends on how busy the bus is. Software therefore polls a busy flag in a status register. When a read completes, the returned word lands in the data register and the busy flag drops on the same clock edge. Configuration cycles also assert one of four device-select lines, chosen directly by the device-number field of the programmed address. While a transaction is running, every host write to the address, data and command registers is discarded. The values presented to the master therefore cannot change under it.

Top module: `pci_indirect_eng`

## Requirements
- R1: After synchronous active-low reset, all four registers read 0, `m_req` is 0 and `m_idsel` is 0.
- R2: Writing the command register (select 2) with code 6, 14 or 12 (memory reads) or 10 (configuration read) in bits [3:0] and bit 8 set raises `m_req` in the next cycle. In that cycle `m_cmd` equals the code and `m_addr` equals the address register (select 0).
- R3: A `m_done` pulse while a read is outstanding stores `m_rdata` in the data register (select 1) on that edge.
- R4: Writing the command register with code 7 or 15 (memory writes) or 11 (configuration write) in bits [3:0] and bit 9 set raises `m_req` in the next cycle, with `m_wdata` equal to the data register.
- R5: Command bits [7:4] are active-low byte enables and appear unchanged on `m_be_n` during the transaction.
- R6: Status register (select 3) bit 0 is 1 from the launching write until the edge that samples `m_done`, and 0 otherwise. `m_req` is only high while it is 1.
- R7: The trigger bit that launched a transaction reads back as 1 in command bits 9/8 until the edge that samples `m_accept`, then reads 0.
- R8: While status bit 0 is 1, host writes to selects 0, 1 and 2 have no effect: the registers keep their values, a new trigger starts nothing, and the master outputs are unchanged.
- R9: A trigger that does not match the command type, or both trigger bits set together, starts no transaction. The code and byte enables are stored, and both trigger bits read 0.
- R10: For a configuration command the device number is address bits [15:11]. Numbers 0 to 3 drive `m_idsel` bit 0 to 3 respectively while busy; other numbers and all memory commands drive `m_idsel` to 0.
- R11: `m_req` stays high, with `m_addr`, `m_cmd`, `m_be_n` and `m_wdata` stable, until the edge that samples `m_accept`; it is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 address, 1 data, 2 command, 3 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| m_req | output | 1 | Transaction request to the PCI master |
| m_cmd | output | 4 | PCI command code |
| m_addr | output | 32 | Target address |
| m_be_n | output | 4 | Byte enables, active low |
| m_wdata | output | 32 | Write data |
| m_accept | input | 1 | Master has taken the request |
| m_done | input | 1 | Master has finished the transaction |
| m_rdata | input | 32 | Read data, valid with `m_done` |
| m_idsel | output | 4 | Device-select lines for configuration cycles |

## Verification
The assertions assume that the PCI master obeys the handshake. It pulses `m_accept` only while `m_req` is high. It pulses `m_done` only after an accept and never in the same cycle. It gives at most one `m_done` per transaction. The bench models the master with two tasks that each raise a single one-cycle pulse. Each task is called only after the expected state has been checked. Host writes are issued as single-cycle strobes, some of them while a transaction is pending, so the discard rule is exercised without breaking the handshake.

// File: rtl/pie_pkg.sv
// Package: shared types, field positions and command classification for
// the indirect PCI transaction launcher.
// Assumes: standard 4-bit PCI command encodings.
package pie_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } pie_state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam logic [3:0] PC_MEM_RD  = 4'h6;
    localparam logic [3:0] PC_MEM_WR  = 4'h7;
    localparam logic [3:0] PC_CFG_RD  = 4'hA;
    localparam logic [3:0] PC_CFG_WR  = 4'hB;
    localparam logic [3:0] PC_MEM_RDM = 4'hC;
    localparam logic [3:0] PC_MEM_RDL = 4'hE;
    localparam logic [3:0] PC_MEM_WRI = 4'hF;

    // True for command codes that move data from the target to the host.
    function automatic logic cmd_is_read(input logic [3:0] c);
        return (c == PC_MEM_RD) || (c == PC_MEM_RDL) ||
               (c == PC_MEM_RDM) || (c == PC_CFG_RD);
    endfunction

    // True for command codes that move data from the host to the target.
    function automatic logic cmd_is_write(input logic [3:0] c);
        return (c == PC_MEM_WR) || (c == PC_MEM_WRI) || (c == PC_CFG_WR);
    endfunction

    // True for configuration-space command codes.
    function automatic logic cmd_is_cfg(input logic [3:0] c);
        return (c == PC_CFG_RD) || (c == PC_CFG_WR);
    endfunction

endpackage

// File: rtl/pie_seq.sv
// Module: pie_seq
// Decodes a command-register write into a launch decision and sequences a
// single transaction through request, accept and done.
// Assumes: m_accept only while requesting, m_done only after accept.
module pie_seq
    import pie_pkg::*;
#(
    parameter int CMD_W  = 4,
    parameter int TRG_RD = 8,
    parameter int TRG_WR = 9,
    parameter int WD_W   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr_i,
    input  logic [WD_W-1:0] wdata_i,
    input  logic            accept_i,
    input  logic            done_i,
    output logic            start_o,
    output logic            start_rd_o,
    output logic            busy_o,
    output logic            req_o,
    output logic            accept_o,
    output logic            rd_done_o
);

    pie_state_e state_q;
    logic       is_rd_q;
    logic [CMD_W-1:0] code;
    logic       trg_rd, trg_wr, rd_ok, wr_ok;

    // Classify the written command and its trigger bits.
    always_comb begin
        code   = wdata_i[CMD_W-1:0];
        trg_rd = wdata_i[TRG_RD];
        trg_wr = wdata_i[TRG_WR];
        rd_ok  = trg_rd && !trg_wr && cmd_is_read(code);
        wr_ok  = trg_wr && !trg_rd && cmd_is_write(code);
    end

    assign start_o    = cmd_wr_i && (state_q == ST_IDLE) && (rd_ok || wr_ok);
    assign start_rd_o = rd_ok;
    assign busy_o     = (state_q != ST_IDLE);
    assign req_o      = (state_q == ST_REQ);
    assign accept_o   = (state_q == ST_REQ) && accept_i;
    assign rd_done_o  = (state_q == ST_WAIT) && done_i && is_rd_q;

    // Transaction state machine and direction latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            is_rd_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_o) begin
                    state_q <= ST_REQ;
                    is_rd_q <= rd_ok;
                end
                ST_REQ:  if (accept_i) state_q <= ST_WAIT;
                ST_WAIT: if (done_i)   state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> busy_o);
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && done_i) |=> !busy_o);
    p_accept_drops_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !req_o);
    p_start_raises_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> req_o);

endmodule

// File: rtl/pie_regfile.sv
// Module: pie_regfile
// Holds the address, data and command registers, returns the selected
// register to the host and discards host writes while a transaction runs.
// Assumes: accept_i and rd_done_i only pulse while busy_i is high.
module pie_regfile
    import pie_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CMD_W  = 4,
    parameter int BE_W   = 4,
    parameter int TRG_RD = 8,
    parameter int TRG_WR = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_i,
    input  logic [1:0]       host_sel_i,
    input  logic [DW-1:0]    host_wdata_i,
    input  logic             busy_i,
    input  logic             start_i,
    input  logic             start_rd_i,
    input  logic             accept_i,
    input  logic             rd_done_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic [DW-1:0]    host_rdata_o,
    output logic [AW-1:0]    addr_o,
    output logic [DW-1:0]    data_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic [BE_W-1:0]  be_n_o
);

    localparam int BE_LSB = CMD_W;

    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;
    logic [CMD_W-1:0] cmd_q;
    logic [BE_W-1:0]  be_n_q;
    logic             trg_rd_q, trg_wr_q;
    logic             wr_ok;

    assign wr_ok = host_wr_i && !busy_i;

    // Address register: host writable while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                addr_q <= '0;
        else if (wr_ok && host_sel_i == SEL_ADDR)  addr_q <= host_wdata_i[AW-1:0];
    end

    // Data register: read completion has priority over host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                data_q <= '0;
        else if (rd_done_i)                        data_q <= rd_data_i;
        else if (wr_ok && host_sel_i == SEL_DATA)  data_q <= host_wdata_i;
    end

    // Command register: code, byte enables and self-clearing triggers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            be_n_q   <= '0;
            trg_rd_q <= 1'b0;
            trg_wr_q <= 1'b0;
        end else if (wr_ok && host_sel_i == SEL_CMD) begin
            cmd_q    <= host_wdata_i[CMD_W-1:0];
            be_n_q   <= host_wdata_i[BE_LSB +: BE_W];
            trg_rd_q <= start_i && start_rd_i;
            trg_wr_q <= start_i && !start_rd_i;
        end else if (accept_i) begin
            trg_rd_q <= 1'b0;
            trg_wr_q <= 1'b0;
        end
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata_o = '0;
        case (host_sel_i)
            SEL_ADDR: host_rdata_o[AW-1:0] = addr_q;
            SEL_DATA: host_rdata_o = data_q;
            SEL_CMD: begin
                host_rdata_o[CMD_W-1:0]        = cmd_q;
                host_rdata_o[BE_LSB +: BE_W]   = be_n_q;
                host_rdata_o[TRG_RD]           = trg_rd_q;
                host_rdata_o[TRG_WR]           = trg_wr_q;
            end
            default:  host_rdata_o[0] = busy_i;
        endcase
    end

    assign addr_o = addr_q;
    assign data_o = data_q;
    assign cmd_o  = cmd_q;
    assign be_n_o = be_n_q;

    p_trig_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> (!trg_rd_q && !trg_wr_q));
    p_trig_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_rd_q || trg_wr_q) |-> busy_i);
    p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (!busy_i || ($stable(addr_q) && $stable(cmd_q) && $stable(be_n_q))));
    p_trig_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(trg_rd_q && trg_wr_q));

endmodule

// File: rtl/pie_idsel_dec.sv
// Module: pie_idsel_dec
// Maps the device-number field of a configuration address onto one
// device-select line per device; numbers beyond the line count select none.
// Assumes: enable_i is already qualified with busy and configuration type.
module pie_idsel_dec #(
    parameter int N_SEL = 4,
    parameter int DEV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [DEV_W-1:0] dev_i,
    output logic [N_SEL-1:0] sel_o
);

    // One comparator per select line.
    for (genvar g = 0; g < N_SEL; g++) begin : g_line
        assign sel_o[g] = enable_i && (dev_i == DEV_W'(g));
    end

    p_idsel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));
    p_idsel_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|sel_o) |-> enable_i);

endmodule

// File: rtl/pci_indirect_eng.sv
// Module: pci_indirect_eng (top)
// Register-driven launcher for single PCI transactions: host registers,
// launch decode, request handshake toward a PCI master and device select.
// Assumes: master handshake as described in pie_seq; synchronous reset.
module pci_indirect_eng
    import pie_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int N_SEL   = 4,
    parameter int DEV_LSB = 11,
    parameter int DEV_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [1:0]       host_sel,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             m_req,
    output logic [3:0]       m_cmd,
    output logic [AW-1:0]    m_addr,
    output logic [DW/8-1:0]  m_be_n,
    output logic [DW-1:0]    m_wdata,
    input  logic             m_accept,
    input  logic             m_done,
    input  logic [DW-1:0]    m_rdata,
    output logic [N_SEL-1:0] m_idsel
);

    localparam int CMD_W  = 4;
    localparam int BE_W   = DW / 8;
    localparam int TRG_RD = CMD_W + BE_W;
    localparam int TRG_WR = TRG_RD + 1;

    logic start, start_rd, busy, accept_p, rd_done;
    logic cmd_wr;

    assign cmd_wr = host_wr && (host_sel == SEL_CMD);

    pie_seq #(
        .CMD_W (CMD_W), .TRG_RD(TRG_RD), .TRG_WR(TRG_WR), .WD_W(DW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr_i  (cmd_wr),
        .wdata_i   (host_wdata),
        .accept_i  (m_accept),
        .done_i    (m_done),
        .start_o   (start),
        .start_rd_o(start_rd),
        .busy_o    (busy),
        .req_o     (m_req),
        .accept_o  (accept_p),
        .rd_done_o (rd_done)
    );

    pie_regfile #(
        .AW(AW), .DW(DW), .CMD_W(CMD_W), .BE_W(BE_W),
        .TRG_RD(TRG_RD), .TRG_WR(TRG_WR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_i   (host_wr),
        .host_sel_i  (host_sel),
        .host_wdata_i(host_wdata),
        .busy_i      (busy),
        .start_i     (start),
        .start_rd_i  (start_rd),
        .accept_i    (accept_p),
        .rd_done_i   (rd_done),
        .rd_data_i   (m_rdata),
        .host_rdata_o(host_rdata),
        .addr_o      (m_addr),
        .data_o      (m_wdata),
        .cmd_o       (m_cmd),
        .be_n_o      (m_be_n)
    );

    pie_idsel_dec #(.N_SEL(N_SEL), .DEV_W(DEV_W)) u_idsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable_i(busy && cmd_is_cfg(m_cmd)),
        .dev_i   (m_addr[DEV_LSB +: DEV_W]),
        .sel_o   (m_idsel)
    );

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_accept) |=> (m_req && $stable(m_addr) && $stable(m_cmd)
                                  && $stable(m_be_n) && $stable(m_wdata)));
    p_idsel_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_idsel) |-> busy);

endmodule

// File: tb/pci_indirect_eng_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module pci_indirect_eng_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        m_req;
    logic [3:0]  m_cmd;
    logic [31:0] m_addr;
    logic [3:0]  m_be_n;
    logic [31:0] m_wdata;
    logic        m_accept = 1'b0;
    logic        m_done = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [3:0]  m_idsel;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pci_indirect_eng u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .m_req(m_req),
        .m_cmd(m_cmd), .m_addr(m_addr), .m_be_n(m_be_n), .m_wdata(m_wdata),
        .m_accept(m_accept), .m_done(m_done), .m_rdata(m_rdata),
        .m_idsel(m_idsel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] sel, output logic [31:0] d);
        host_sel = sel;
        #1 d = host_rdata;
    endtask

    task automatic accept_pulse();
        @(negedge clk); m_accept = 1'b1;
        @(negedge clk); m_accept = 1'b0;
    endtask

    task automatic done_pulse(input logic [31:0] d);
        @(negedge clk); m_done = 1'b1; m_rdata = d;
        @(negedge clk); m_done = 1'b0; m_rdata = '0;
    endtask

    function automatic logic [31:0] cmdw(input logic [3:0] c, input logic [3:0] be,
                                         input logic rt, input logic wt);
        return {22'd0, wt, rt, be, c};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            hrd(2'(s), v);
            chk("R1 reg after reset", v, 32'd0);
        end
        chk("R1 m_req", {31'd0, m_req}, 32'd0);
        chk("R1 m_idsel", {28'd0, m_idsel}, 32'd0);
    endtask

    task automatic t_mem_read();
        logic [31:0] v;
        hwr(2'd1, 32'h0000_1111);
        hwr(2'd0, 32'h1000_0040);
        hwr(2'd2, cmdw(4'h6, 4'h0, 1'b1, 1'b0));
        chk("R2 m_req", {31'd0, m_req}, 32'd1);
        chk("R2 m_cmd", {28'd0, m_cmd}, 32'h6);
        chk("R2 m_addr", m_addr, 32'h1000_0040);
        chk("R5 m_be_n all on", {28'd0, m_be_n}, 32'h0);
        hrd(2'd3, v); chk("R6 busy set", v, 32'd1);
        hrd(2'd2, v); chk("R7 rd trigger pending", v, 32'h0000_0106);
        chk("R10 idsel memory", {28'd0, m_idsel}, 32'd0);
        accept_pulse();
        chk("R11 req low after accept", {31'd0, m_req}, 32'd0);
        hrd(2'd2, v); chk("R7 trigger cleared", v, 32'h0000_0006);
        hrd(2'd3, v); chk("R6 busy after accept", v, 32'd1);
        hwr(2'd1, 32'hDEAD_0000);
        hrd(2'd1, v); chk("R8 data write during read", v, 32'h0000_1111);
        done_pulse(32'hCAFE_F00D);
        hrd(2'd1, v); chk("R3 read data stored", v, 32'hCAFE_F00D);
        hrd(2'd3, v); chk("R6 busy cleared", v, 32'd0);
    endtask

    task automatic t_read_kinds();
        logic [31:0] v;
        logic [3:0] codes [2] = '{4'hE, 4'hC};
        foreach (codes[i]) begin
            hwr(2'd2, cmdw(codes[i], 4'h3, 1'b1, 1'b0));
            chk("R2 other read launches", {31'd0, m_req}, 32'd1);
            chk("R2 other read code", {28'd0, m_cmd}, {28'd0, codes[i]});
            chk("R5 be_n as written", {28'd0, m_be_n}, 32'h3);
            accept_pulse();
            done_pulse(32'h0A0B_0C00 + 32'(i));
            hrd(2'd1, v); chk("R3 read data", v, 32'h0A0B_0C00 + 32'(i));
        end
    endtask

    task automatic t_mem_write();
        logic [31:0] v;
        hwr(2'd1, 32'h1234_5678);
        hwr(2'd0, 32'h2000_0100);
        hwr(2'd2, cmdw(4'h7, 4'hA, 1'b0, 1'b1));
        chk("R4 m_req", {31'd0, m_req}, 32'd1);
        chk("R4 m_wdata", m_wdata, 32'h1234_5678);
        chk("R5 m_be_n", {28'd0, m_be_n}, 32'hA);
        hrd(2'd2, v); chk("R7 wr trigger pending", v, 32'h0000_02A7);
        repeat (3) @(negedge clk);
        chk("R11 req held", {31'd0, m_req}, 32'd1);
        chk("R11 addr held", m_addr, 32'h2000_0100);
        hwr(2'd2, cmdw(4'h6, 4'h0, 1'b1, 1'b0));
        hwr(2'd0, 32'h3333_3333);
        chk("R8 cmd unchanged", {28'd0, m_cmd}, 32'h7);
        chk("R8 addr unchanged", m_addr, 32'h2000_0100);
        accept_pulse();
        done_pulse(32'hFFFF_FFFF);
        hrd(2'd1, v); chk("R3 write does not load data", v, 32'h1234_5678);
        hrd(2'd3, v); chk("R6 idle after write", v, 32'd0);
        chk("R8 no relaunch", {31'd0, m_req}, 32'd0);
    endtask

    task automatic t_mismatch();
        logic [31:0] v;
        hwr(2'd2, cmdw(4'h7, 4'h5, 1'b1, 1'b0));
        chk("R9 rd trig on write cmd", {31'd0, m_req}, 32'd0);
        hrd(2'd2, v); chk("R9 fields stored", v, 32'h0000_0057);
        hwr(2'd2, cmdw(4'h6, 4'h0, 1'b1, 1'b1));
        chk("R9 both triggers", {31'd0, m_req}, 32'd0);
        hrd(2'd3, v); chk("R9 not busy", v, 32'd0);
        hwr(2'd2, cmdw(4'hF, 4'h0, 1'b0, 1'b1));
        chk("R4 invalidate write launches", {31'd0, m_req}, 32'd1);
        accept_pulse();
        done_pulse(32'd0);
    endtask

    task automatic t_config();
        for (int d = 0; d < 6; d++) begin
            hwr(2'd0, 32'(d) << 11);
            hwr(2'd2, cmdw((d % 2 == 0) ? 4'hA : 4'hB, 4'h0, d % 2 == 0, d % 2 == 1));
            chk("R10 idsel", {28'd0, m_idsel}, (d < 4) ? (32'd1 << d) : 32'd0);
            accept_pulse();
            chk("R10 idsel held", {28'd0, m_idsel}, (d < 4) ? (32'd1 << d) : 32'd0);
            done_pulse(32'd0);
            chk("R10 idsel idle", {28'd0, m_idsel}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem_read();
        t_read_kinds();
        t_mem_write();
        t_mismatch();
        t_config();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule